// File: doc/BRIEF.md
# Dual-Strobe Decade Up/Down Counter

This block holds one decimal digit in 8421 code. It counts in the range 0 to 9 and wraps at both ends. No direction pin exists. The block has one strobe for counting up and one strobe for counting down. Both strobes rest high. A step happens on the rising edge of one strobe, and only while the other strobe is high. The whole block runs on one system clock. Each strobe is sampled on that clock, and each rising edge becomes a step of one cycle.

The block has three other controls:
- A synchronous active-high clear.
- An active-low parallel preset.
- Two active-low ripple outputs that chain digits into a multi-digit counter.

The carry output of a digit drives the up strobe of the next digit. The borrow output drives the down strobe of the next digit. Because of this, the whole chain advances on the same clock edge.

Top module: `bcd_dual_strobe_counter`

## Requirements
- R1: When `clear` is high at a clock edge, the digit becomes 0 after that edge. Clear wins over the preset and over both strobes.
- R2: When `preset_n` is low and `clear` is low at a clock edge, the digit takes `preset_val` after that edge. The preset wins over any strobe edge in that cycle.
- R3: A rising edge of `up_strobe` while `dn_strobe` is high adds one to the digit, on the clock edge where the new high level is first sampled. From 9 the digit wraps to 0.
- R4: A rising edge of `dn_strobe` while `up_strobe` is high takes one from the digit, on the same kind of clock edge. From 0 the digit wraps to 9.
- R5: A rising edge on one strobe while the other strobe is low is ignored, and the digit holds.
- R6: A strobe held high gives exactly one step. A falling edge gives no step.
- R7: `carry_n` is low exactly while the digit is 9 and `up_strobe` is low. Otherwise it is high.
- R8: `borrow_n` is low exactly while the digit is 0 and `dn_strobe` is low. Otherwise it is high.
- R9: The preset may load a value from 10 to 15. An up step from such a value gives 0. A down step from such a value gives the value minus one.
- R10: If both strobes rise in the same sampled cycle, the digit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| clear | input | 1 | Synchronous clear, active high, highest priority |
| preset_n | input | 1 | Parallel preset enable, active low |
| preset_val | input | 4 | Value loaded by the preset (bit 3 is weight 8, bit 0 is weight 1) |
| up_strobe | input | 1 | Count-up strobe, rests high, steps on its rising edge |
| dn_strobe | input | 1 | Count-down strobe, rests high, steps on its rising edge |
| digit | output | 4 | Registered digit value in 8421 code |
| carry_n | output | 1 | Active-low carry to the next digit's up strobe |
| borrow_n | output | 1 | Active-low borrow to the next digit's down strobe |

## Verification
The bench checks these cases:
- **Wraps at 9 and at 0.** A design that counts through the binary codes above 9 is caught here.
- **Clear at the same time as a preset, and a preset at the same time as an up edge.** A design with the wrong priority is caught here.
- **A strobe that rises while the other strobe is low, and both strobes rising together.** A design that ignores the enable condition would step the digit here.
- **A strobe held high over several cycles.** A design that counts on levels instead of edges would add extra counts here.
- **Presets above 9 followed by steps.** This checks the rules for out-of-range values.
- **Two digits chained through carry and borrow.** A wrong carry or borrow level shows up as a wrong tens digit.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } step_op_e;
endpackage

// File: rtl/bcd_strobe_edge.sv
module bcd_strobe_edge (
  input  logic clk,
  input  logic clear,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  // Previous sample resets high so a strobe resting high gives no step after clear
  always_ff @(posedge clk) begin
    if (clear) prev_q <= 1'b1;
    else       prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R6
  rise_single_chk: assert property (@(posedge clk) disable iff (clear)
    rise |=> !rise);
endmodule

// File: rtl/bcd_step_ctl.sv
module bcd_step_ctl
  import bcd_cnt_pkg::*;
(
  input  logic     clear,
  input  logic     preset_n,
  input  logic     up_rise,
  input  logic     dn_rise,
  input  logic     up_lvl,
  input  logic     dn_lvl,
  output step_op_e op
);
  always_comb begin
    if (clear)                               op = OP_CLEAR;
    else if (!preset_n)                      op = OP_LOAD;
    else if (up_rise && dn_lvl && !dn_rise)  op = OP_INC;
    else if (dn_rise && up_lvl && !up_rise)  op = OP_DEC;
    else                                     op = OP_HOLD;
  end
endmodule

// File: rtl/bcd_digit_reg.sv
module bcd_digit_reg
  import bcd_cnt_pkg::*;
#(
  parameter int DW   = 4,
  parameter int TOPV = 9
) (
  input  logic          clk,
  input  logic          clear,
  input  step_op_e      op,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] value
);
  localparam logic [DW-1:0] TOP  = DW'(TOPV);
  localparam logic [DW-1:0] ZERO = '0;

  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR: value <= ZERO;
      OP_LOAD:  value <= data;
      OP_INC:   value <= (value >= TOP) ? ZERO : value + 1'b1;
      OP_DEC:   value <= (value == ZERO) ? TOP : value - 1'b1;
      default:  value <= value;
    endcase
  end

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (clear)
    op == OP_LOAD |=> value == $past(data));
  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (clear)
    (op == OP_INC && value < TOP) |=> value == DW'($past(value) + 1'b1));
  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (clear)
    (op == OP_DEC && value != ZERO) |=> value == DW'($past(value) - 1'b1));
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (clear)
    op == OP_HOLD |=> $stable(value));
endmodule

// File: rtl/bcd_dual_strobe_counter.sv
module bcd_dual_strobe_counter
  import bcd_cnt_pkg::*;
#(
  parameter int DW   = 4,
  parameter int TOPV = 9
) (
  input  logic          clk,
  input  logic          clear,
  input  logic          preset_n,
  input  logic [DW-1:0] preset_val,
  input  logic          up_strobe,
  input  logic          dn_strobe,
  output logic [DW-1:0] digit,
  output logic          carry_n,
  output logic          borrow_n
);
  localparam logic [DW-1:0] TOP = DW'(TOPV);

  logic     up_rise, dn_rise;
  step_op_e op;

  bcd_strobe_edge u_up_edge (.clk(clk), .clear(clear), .lvl(up_strobe), .rise(up_rise));
  bcd_strobe_edge u_dn_edge (.clk(clk), .clear(clear), .lvl(dn_strobe), .rise(dn_rise));

  bcd_step_ctl u_ctl (
    .clear(clear), .preset_n(preset_n),
    .up_rise(up_rise), .dn_rise(dn_rise),
    .up_lvl(up_strobe), .dn_lvl(dn_strobe),
    .op(op)
  );

  bcd_digit_reg #(.DW(DW), .TOPV(TOPV)) u_reg (
    .clk(clk), .clear(clear), .op(op), .data(preset_val), .value(digit)
  );

  assign carry_n  = ~((digit == TOP) & ~up_strobe);
  assign borrow_n = ~((digit == '0) & ~dn_strobe);

  // R7
  carry_low_chk: assert property (@(posedge clk) disable iff (clear)
    !carry_n |-> (digit == TOP && !up_strobe));
  // R8
  borrow_low_chk: assert property (@(posedge clk) disable iff (clear)
    !borrow_n |-> (digit == '0 && !dn_strobe));
  // R10
  dual_rise_hold_chk: assert property (@(posedge clk) disable iff (clear)
    (up_rise && dn_rise && preset_n) |=> $stable(digit));
endmodule

// File: tb/bcd_dual_strobe_counter_bench.sv
`timescale 1ns/1ps
module bcd_dual_strobe_counter_bench;
  logic       clk = 1'b0;
  logic       clr = 1'b1, ldn = 1'b1, up_s = 1'b1, dn_s = 1'b1;
  logic [3:0] pdat = 4'd0;
  logic [3:0] units, tens;
  logic       c_n, b_n, tc_n, tb_n;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  typedef struct { logic [3:0] u; logic [3:0] t; string tag; } exp_t;
  exp_t sb[$];

  logic [3:0] mu = 0, mt = 0;
  logic mpu = 1, mpd = 1, mtpu = 1, mtpd = 1;

  always #4 clk = ~clk;

  bcd_dual_strobe_counter u_bcd_dual_strobe_counter (
    .clk(clk), .clear(clr), .preset_n(ldn), .preset_val(pdat),
    .up_strobe(up_s), .dn_strobe(dn_s), .digit(units), .carry_n(c_n), .borrow_n(b_n));

  bcd_dual_strobe_counter u_tens (
    .clk(clk), .clear(clr), .preset_n(1'b1), .preset_val(4'd0),
    .up_strobe(c_n), .dn_strobe(b_n), .digit(tens), .carry_n(tc_n), .borrow_n(tb_n));

  task automatic mdl(inout logic [3:0] v, inout logic pu, inout logic pd,
                     input logic u, input logic d, input logic c,
                     input logic l, input logic [3:0] dat);
    logic ur, dr;
    ur = u & ~pu;
    dr = d & ~pd;
    if (c) begin
      v = 4'd0; pu = 1'b1; pd = 1'b1;
    end else begin
      pu = u; pd = d;
      if (!l)                   v = dat;
      else if (ur && d && !dr)  v = (v >= 4'd9) ? 4'd0 : v + 4'd1;
      else if (dr && u && !ur)  v = (v == 4'd0) ? 4'd9 : v - 4'd1;
    end
  endtask

  task automatic check1(input logic act, input logic ex, input string tag);
    total++;
    if (act !== ex) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, ex);
    end
  endtask

  task automatic step(input logic u, input logic d, input logic c, input logic l,
                      input logic [3:0] dat, input string tag);
    logic ec, eb;
    @(negedge clk);
    up_s = u; dn_s = d; clr = c; ldn = l; pdat = dat;
    #1;
    ec = !(mu == 4'd9 && !u);
    eb = !(mu == 4'd0 && !d);
    if (!c) begin
      check1(c_n, ec, "R7 carry_n");
      check1(b_n, eb, "R8 borrow_n");
    end
    mdl(mu, mpu, mpd, u, d, c, l, dat);
    mdl(mt, mtpu, mtpd, ec, eb, c, 1'b1, 4'd0);
    @(posedge clk);
    sb.push_back('{u: mu, t: mt, tag: tag});
  endtask

  task automatic up_pulse(input string tag);
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, tag);
    step(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, tag);
  endtask

  task automatic dn_pulse(input string tag);
    step(1'b1, 1'b0, 1'b0, 1'b1, 4'd0, tag);
    step(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, tag);
  endtask

  // Monitor: pops the expected item for the edge just passed and compares
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (units !== e.u || tens !== e.t) begin
        bad++;
        $display("FAIL %s units=%0d tens=%0d exp units=%0d tens=%0d",
                 e.tag, units, tens, e.u, e.t);
      end
    end
  end

  initial begin
    step(1, 1, 1, 1, 0, "R1 reset");
    step(1, 1, 0, 1, 0, "R1 after reset");
    for (int i = 0; i < 9; i++) up_pulse("R3 count up");
    step(0, 1, 0, 1, 0, "R7 carry at 9");
    step(1, 1, 0, 1, 0, "R3 wrap 9 to 0");
    step(1, 0, 0, 1, 0, "R8 borrow at 0");
    step(1, 1, 0, 1, 0, "R4 wrap 0 to 9");
    for (int i = 0; i < 3; i++) dn_pulse("R4 count down");
    step(1, 1, 0, 1, 0, "R6 held high");
    step(0, 1, 0, 1, 0, "R6 falling edge");
    step(0, 1, 0, 1, 0, "R6 held low");
    step(1, 1, 0, 1, 0, "R6 one step");
    step(1, 1, 0, 1, 0, "R6 held high");
    step(1, 1, 0, 1, 0, "R6 held high");
    step(0, 0, 0, 1, 0, "R5 both low");
    step(1, 0, 0, 1, 0, "R5 up edge dn low");
    step(0, 0, 0, 1, 0, "R5 both low");
    step(0, 1, 0, 1, 0, "R5 dn edge up low");
    step(1, 1, 0, 1, 0, "R3 up edge");
    step(0, 0, 0, 1, 0, "R10 both low");
    step(1, 1, 0, 1, 0, "R10 both rise");
    step(0, 1, 0, 1, 0, "R2 setup");
    step(1, 1, 0, 0, 4'd3, "R2 load over up edge");
    step(1, 1, 1, 0, 4'd8, "R1 clear over load");
    step(1, 1, 0, 0, 4'd12, "R9 load 12");
    up_pulse("R9 up from 12");
    step(1, 1, 0, 0, 4'd13, "R9 load 13");
    dn_pulse("R9 down from 13");
    step(1, 1, 0, 0, 4'd15, "R9 load 15");
    up_pulse("R9 up from 15");
    step(1, 1, 1, 1, 0, "R1 clear before chain");
    for (int i = 0; i < 23; i++) up_pulse("R3 R7 chain up");
    for (int i = 0; i < 5; i++) dn_pulse("R4 R8 chain down");
    step(1, 1, 0, 1, 0, "R5 chain idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule